// File: doc/BRIEF.md
# Multi-Cycle Logical Right Shift Unit

This block executes one instruction, a 16-bit logical right shift, against its own bank of four 16-bit registers. An opcode word arrives with a one-cycle start strobe. If the word is a shift opcode, the block latches two things from it. One field chooses the target register and one bit chooses a shift of one or two places. The block then stays busy for the instruction's fixed latency. In the last busy cycle it writes the zero-filled result back to the same register and updates the sign and zero flags.

The latency depends on the shift amount: six cycles for one place and eight for two. The instruction cannot be interrupted, so the interrupt-allow output stays low for the whole run. A word outside the opcode range gives a one-cycle error pulse and changes nothing. A preload port writes the registers directly, and an asynchronous read port lets the surrounding logic or a test observe them.

Top module: `srl_exec`

## Requirements
- R1: A start while idle with an opcode in 0x0060..0x0067 is accepted: opcode bits 15:3 must equal 0b0000000001100. `busy` rises on the edge that samples the start.
- R2: A start while idle with any other opcode word drives `err` high for exactly the next cycle. `busy` stays low, and no register or flag changes.
- R3: Opcode bit 2 selects the shift amount: 0 shifts right by one place, 1 shifts right by two places.
- R4: Opcode bits 1:0 select the target register: 0 selects R0, 1 selects R1, 2 selects R2 and 3 selects R3.
- R5: The shift is logical. Vacated high bits are zero and the discarded low bits are lost. The result replaces the target register, and the other registers keep their values.
- R6: When `done` is high, `zero_flag` is 1 exactly when the 16-bit result is zero. `sign_flag` equals result bit 15, which is always 0.
- R7: `busy` is high for 6 consecutive cycles after a one-place start and for 8 after a two-place start. `done` is high only in the last of those cycles, and the register and flags already hold the new values in that cycle.
- R8: `int_ok` is low in every cycle where an instruction is executing and high otherwise.
- R9: A start that arrives while `busy` is high is ignored. Its opcode changes no register and adds no cycles.
- R10: A synchronous active-high reset clears all four registers, both flags, `busy`, `done` and `err`.
- R11: With `ld_en` high, `ld_data` is written to the register numbered `ld_sel` on the next clock edge. `rd_data` shows the register numbered `rd_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe for one instruction |
| opcode | input | 16 | Instruction word sampled with start |
| ld_en | input | 1 | Preload write enable |
| ld_sel | input | 2 | Preload register number |
| ld_data | input | 16 | Preload value |
| rd_sel | input | 2 | Read register number |
| rd_data | output | 16 | Selected register contents |
| busy | output | 1 | Instruction executing |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal opcode pulse |
| sign_flag | output | 1 | Sign of last result |
| zero_flag | output | 1 | Last result was zero |
| int_ok | output | 1 | Interrupt may be accepted |

## Verification
Take the clock edge that samples an accepted start as edge one. The result, both flags and `done` all appear after edge six for a one-place shift and after edge eight for a two-place shift. The monitor counts the falling-edge samples with `busy` high and compares that count with the expected latency at the `done` sample. An illegal word gives its `err` pulse one cycle after the start, so the bench samples exactly one falling edge later. It then confirms that the pulse is gone a cycle after that. All outputs are sampled at falling edges, half a period away from the edges that update them.

// File: rtl/srl_exec.sv
module srl_exec #(
  parameter int          W        = 16,
  parameter int          LAT_ONE  = 6,
  parameter int          LAT_TWO  = 8,
  parameter logic [15:0] OPC_BASE = 16'h0060
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [15:0]  opcode,
  input  logic         ld_en,
  input  logic [1:0]   ld_sel,
  input  logic [W-1:0] ld_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic         sign_flag,
  output logic         zero_flag,
  output logic         int_ok
);
  localparam int NREG = 4;
  localparam int CW   = $clog2(LAT_TWO + 1);

  logic [W-1:0]  rf [NREG];
  logic [1:0]    tsel;
  logic          tamt;
  logic [CW-1:0] cnt;
  logic          legal;
  logic [W-1:0]  res;

  assign legal   = (opcode[15:3] == OPC_BASE[15:3]);
  assign res     = tamt ? (rf[tsel] >> 2) : (rf[tsel] >> 1);
  assign rd_data = rf[rd_sel];
  assign int_ok  = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      sign_flag <= 1'b0;
      zero_flag <= 1'b0;
      cnt       <= '0;
      tsel      <= '0;
      tamt      <= 1'b0;
    end else begin
      err <= 1'b0;
      if (ld_en) rf[ld_sel] <= ld_data;
      if (!busy) begin
        done <= 1'b0;
        if (start) begin
          if (legal) begin
            busy <= 1'b1;
            tsel <= opcode[1:0];
            tamt <= opcode[2];
            cnt  <= opcode[2] ? CW'(LAT_TWO - 1) : CW'(LAT_ONE - 1);
          end else begin
            err <= 1'b1;
          end
        end
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          rf[tsel]  <= res;
          sign_flag <= res[W-1];
          zero_flag <= (res == '0);
          done      <= 1'b1;
        end
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b0;
        end
      end
    end
  end
endmodule

module srl_exec_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [15:0] opcode,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        sign_flag,
  input logic        int_ok
);
  logic legal;
  assign legal = (opcode[15:3] == 13'h000C);

  a_r1_accept: assert property (@(posedge clk) disable iff (rst)
    start && !busy && legal |=> busy);
  a_r2_illegal: assert property (@(posedge clk) disable iff (rst)
    start && !busy && !legal |=> err && !busy);
  a_r6_sign: assert property (@(posedge clk) disable iff (rst)
    done |-> !sign_flag);
  a_r7_done_in_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  a_r7_done_ends: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy && !done);
  a_r8_no_int: assert property (@(posedge clk) disable iff (rst)
    start && !busy && legal |=> !int_ok);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> busy);
endmodule

bind srl_exec srl_exec_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .opcode(opcode), .busy(busy),
  .done(done), .err(err), .sign_flag(sign_flag), .int_ok(int_ok)
);

// File: tb/sim_srl_exec.sv
module sim_srl_exec;
  localparam int PER = 10;

  logic clk = 0, rst = 1, start = 0, ld_en = 0;
  logic [15:0] opcode = '0, ld_data = '0, rd_data;
  logic [1:0]  ld_sel = '0, rd_sel = '0;
  logic busy, done, err, sign_flag, zero_flag, int_ok;

  srl_exec u0 (.clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .busy(busy), .done(done), .err(err),
    .sign_flag(sign_flag), .zero_flag(zero_flag), .int_ok(int_ok));

  always #(PER/2) clk = ~clk;

  typedef struct { logic [15:0] val; logic sgn; logic zr; int lat; } item_t;
  item_t q[$];
  logic [15:0] mdl [4];
  int n_chk = 0, n_fail = 0, bcnt = 0, n_done = 0;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && busy) bcnt++;
    if (!rst && done) begin
      item_t it;
      n_done++;
      if (q.size() == 0) check("R9 unexpected done", 16'd1, 16'd0);
      else begin
        it = q.pop_front();
        check("R5 result", rd_data, it.val);
        check("R6 zero flag", {15'd0, zero_flag}, {15'd0, it.zr});
        check("R6 sign flag", {15'd0, sign_flag}, {15'd0, it.sgn});
        check("R7 latency", 16'(bcnt), 16'(it.lat));
        check("R8 int_ok low", {15'd0, int_ok}, 16'd0);
      end
    end
  end

  task automatic check_regs(string req);
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      #1 check(req, rd_data, mdl[i]);
    end
  endtask

  task automatic load(int idx, logic [15:0] v);
    @(negedge clk);
    ld_en = 1; ld_sel = 2'(idx); ld_data = v;
    @(negedge clk);
    ld_en = 0;
    mdl[idx] = v;
  endtask

  task automatic issue(logic [15:0] op);
    item_t it;
    int r;
    @(negedge clk);
    r = op[1:0];
    if (op[15:3] == 13'h000C) begin
      it.val = op[2] ? (mdl[r] >> 2) : (mdl[r] >> 1);
      it.sgn = it.val[15];
      it.zr  = (it.val == 0);
      it.lat = op[2] ? 8 : 6;
      mdl[r] = it.val;
      q.push_back(it);
      rd_sel = 2'(r);
      bcnt = 0;
      opcode = op; start = 1;
      @(negedge clk);
      start = 0;
      while (busy) @(negedge clk);
      check("R8 int_ok high when idle", {15'd0, int_ok}, 16'd1);
    end else begin
      opcode = op; start = 1;
      @(negedge clk);
      start = 0;
      check("R2 err pulse", {15'd0, err}, 16'd1);
      check("R2 busy stays low", {15'd0, busy}, 16'd0);
      @(negedge clk);
      check("R2 err one cycle", {15'd0, err}, 16'd0);
      check_regs("R2 regs unchanged");
    end
  endtask

  initial begin
    #(PER * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check("R10 busy", {15'd0, busy}, 16'd0);
    check("R10 done/err", {14'd0, done, err}, 16'd0);
    check("R10 flags", {14'd0, sign_flag, zero_flag}, 16'd0);
    check("R8 int_ok idle", {15'd0, int_ok}, 16'd1);
    check_regs("R10 regs");
    // R11 preload
    load(0, 16'h8001); load(1, 16'h0003); load(2, 16'hFFFF); load(3, 16'h0001);
    check_regs("R11 preload");
    // R1 R3 R4 R5 R6 R7
    issue(16'h0060);
    issue(16'h0065);
    issue(16'h0066);
    issue(16'h0063);
    issue(16'h0064);
    check_regs("R4 R5 other regs");
    // R2 illegal words
    issue(16'h0068);
    issue(16'h0000);
    issue(16'hFFFF);
    issue(16'h0160);
    // R9 start while busy ignored
    load(1, 16'hF0F0);
    @(negedge clk);
    mdl[1] = 16'hF0F0 >> 2;
    q.push_back('{val: 16'h3C3C, sgn: 1'b0, zr: 1'b0, lat: 8});
    rd_sel = 1; bcnt = 0;
    opcode = 16'h0065; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); opcode = 16'h0062; start = 1;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R9 no extra busy", {15'd0, busy}, 16'd0);
    check_regs("R9 ignored start");
    check("R9 done count", 16'(n_done), 16'd6);
    check("R9 queue empty", 16'(q.size()), 16'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule